// File: doc/BRIEF.md
# Link Controller Status and Interrupt Register

This block holds the 12-bit control and status word of a descriptor-ring link controller. It keeps a run/stop phase, two direction enables (receive and transmit) and seven sticky event flags. It also holds an interrupt enable and a summary interrupt bit, which together drive an active-low interrupt output. Hardware event pulses set the flags. Software clears a flag by writing 1 to its bit. Start and Stop command pulses move the controller between the running and stopped phases.

A bus-cycle monitor is built in. It watches each master-mode bus cycle from the cycle that drives the address. If READY does not come within a parameterised number of clocks, the monitor sets the memory-error flag, releases the bus for one cycle and turns off both directions. The read port is combinational from the register state. Every flag, enable and output is a flop.

Top module: `link_csr`

## Requirements
- R1: Layout of `rd_data`: bit 11 is the interrupt enable, bit 10 the summary interrupt, bit 9 receive-on, bit 8 transmit-on, bit 7 memory error, bit 6 missed frame, bit 5 receive overrun, bit 4 transmit underrun, bit 3 primitive update, bit 2 transmit-descriptor update and bit 1 receive-frame update. After reset `rd_data` is 0, `irq_n` is 1 and the controller is stopped.
- R2: Bit 0 of `rd_data` always reads 0.
- R3: A Start pulse sets each on bit at the next edge if that direction's disable input is low. If the disable is high, the on bit sets at the edge after the disable falls. A disable that rises clears its on bit at the next edge.
- R4: A Stop pulse clears both on bits, all seven flags and the interrupt enable at the next edge, and enters the stopped phase.
- R5: An event pulse sets its flag at the next edge. This holds even when a write of 1 to that flag happens in the same cycle.
- R6: A write of 1 to a flag bit clears it. A write of 0 leaves it unchanged.
- R7: The summary interrupt bit is 1 exactly when at least one of memory error, missed frame, primitive update, transmit-descriptor update or receive-frame update is set. Receive overrun and transmit underrun do not affect it.
- R8: `irq_n` is low one cycle after `rd_data` shows both bit 11 and bit 10 set, and high otherwise.
- R9: Writing 0 to bit 11 clears the enable. Writing 1 sets it only in the running phase; in the stopped phase the write of 1 is ignored.
- R10: A bus cycle begins when `bm_addr` is sampled high; a new `bm_addr` restarts the count. If `bm_ready` is not sampled high within the next LIMIT edges, the LIMIT-th edge sets memory error, clears both on bits and raises `bus_release` for one cycle.
- R11: Writes have no effect on bits 10, 9, 8 and 0.
- R12: Stop takes priority over Start and over event pulses in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Bus reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 12 | Register write data |
| rd_data | output | 12 | Register read value |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| rx_dis | input | 1 | Receive disable level |
| tx_dis | input | 1 | Transmit disable level |
| ev_miss | input | 1 | Frame lost for lack of a buffer |
| ev_ror | input | 1 | Receive FIFO overrun |
| ev_tur | input | 1 | Transmit underrun |
| ev_pint | input | 1 | Provider primitive written |
| ev_tint | input | 1 | Transmit descriptor updated |
| ev_rint | input | 1 | Received frame completed |
| bm_addr | input | 1 | Bus-master address phase begins |
| bm_ready | input | 1 | Bus READY |
| bus_release | output | 1 | One-cycle bus release on timeout |
| irq_n | output | 1 | Interrupt, active low |

## Verification
Every piece of state here shows up on `rd_data` at the edge after it changes, except the registered interrupt pin. A wrong flag, enable or phase bit therefore appears at the read port within one cycle, and on `irq_n` one cycle after that. A wrong stopped phase shows only later, as a write of 1 to the enable that is kept or lost. An off-by-one in the bus monitor moves the memory-error edge by one cycle, so the bench samples both sides of that boundary.

// File: rtl/link_csr_pkg.sv
package link_csr_pkg;
    localparam int CSR_W  = 12;
    localparam int NFLAG  = 7;           // flags occupy bits NFLAG..1
    localparam int B_IE   = 11;
    localparam int B_IRQ  = 10;
    localparam int B_RXON = 9;
    localparam int B_TXON = 8;
    // flag vector index: 0 rint,1 tint,2 pint,3 tur,4 ror,5 miss,6 merr
    localparam logic [NFLAG-1:0] IRQ_MASK = 7'b110_0111;

    typedef struct packed {
        logic [NFLAG-1:0] flg;
        logic             ie;
        logic             stopped;
        logic             irq_n;
    } csr_st_t;

    typedef struct packed {
        logic arm;
        logic on;
    } dir_st_t;
endpackage

// File: rtl/link_csr_dir.sv
module link_csr_dir
    import link_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic kill,
    input  logic dis,
    output logic on
);
    dir_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) st_d.arm = 1'b1;
        if (kill || stop) st_d.arm = 1'b0;
        st_d.on = st_d.arm & ~dis;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign on = st_q.on;
endmodule

// File: rtl/link_csr_tmo.sv
module link_csr_tmo #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic addr,
    input  logic ready,
    output logic fire,
    output logic release_o
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic          rel;
    } tmo_st_t;

    tmo_st_t st_d, st_q;

    always_comb begin
        fire = st_q.busy & ~ready & (st_q.cnt == CW'(LIMIT - 1));
        st_d = st_q;
        st_d.rel = fire;
        if (fire || (st_q.busy && ready)) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (addr) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign release_o = st_q.rel;
endmodule

// File: rtl/link_csr.sv
module link_csr
    import link_csr_pkg::*;
#(
    parameter int LIMIT = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [11:0] wr_data,
    output logic [11:0] rd_data,
    input  logic        cmd_start,
    input  logic        cmd_stop,
    input  logic        rx_dis,
    input  logic        tx_dis,
    input  logic        ev_miss,
    input  logic        ev_ror,
    input  logic        ev_tur,
    input  logic        ev_pint,
    input  logic        ev_tint,
    input  logic        ev_rint,
    input  logic        bm_addr,
    input  logic        bm_ready,
    output logic        bus_release,
    output logic        irq_n
);
    localparam int NDIR = 2;

    csr_st_t          st_d, st_q;
    logic             tmo_fire;
    logic [NFLAG-1:0] ev_vec;
    logic [NFLAG-1:0] clr_vec;
    logic             intr;
    logic [NDIR-1:0]  dis_v;
    logic [NDIR-1:0]  on_v;
    logic             unused_ro;

    assign unused_ro = ^{wr_data[B_IRQ:B_TXON], wr_data[0]};

    link_csr_tmo #(.LIMIT(LIMIT)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bm_addr),
        .ready     (bm_ready),
        .fire      (tmo_fire),
        .release_o (bus_release)
    );

    // index 1 receive, index 0 transmit
    assign dis_v = {rx_dis, tx_dis};

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        link_csr_dir u_dir (
            .clk   (clk),
            .rst_n (rst_n),
            .start (cmd_start),
            .stop  (cmd_stop),
            .kill  (tmo_fire),
            .dis   (dis_v[g]),
            .on    (on_v[g])
        );
    end

    assign ev_vec  = {tmo_fire, ev_miss, ev_ror, ev_tur, ev_pint, ev_tint, ev_rint};
    assign clr_vec = wr_en ? wr_data[NFLAG:1] : '0;
    assign intr    = |(st_q.flg & IRQ_MASK);

    always_comb begin
        st_d       = st_q;
        st_d.flg   = (st_q.flg & ~clr_vec) | ev_vec;
        if (wr_en) begin
            if (!wr_data[B_IE])      st_d.ie = 1'b0;
            else if (!st_q.stopped)  st_d.ie = 1'b1;
        end
        if (cmd_start) st_d.stopped = 1'b0;
        if (cmd_stop) begin
            st_d.stopped = 1'b1;
            st_d.flg     = '0;
            st_d.ie      = 1'b0;
        end
        st_d.irq_n = ~(st_q.ie & intr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.stopped <= 1'b1;
            st_q.irq_n   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = {st_q.ie, intr, on_v[1], on_v[0], st_q.flg, 1'b0};
    assign irq_n   = st_q.irq_n;
endmodule

// File: rtl/link_csr_chk.sv
module link_csr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_stop,
    input logic        ev_miss,
    input logic        wr_en,
    input logic [11:0] wr_data,
    input logic [11:0] rd_data,
    input logic        bus_release,
    input logic        irq_n
);
    // R2
    bit0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[0] == 1'b0);

    // R4
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> rd_data == 12'h000);

    // R5
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_miss && !cmd_stop) |=> rd_data[6]);

    // R6
    write_zero_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[6] && rd_data[6] && !cmd_stop) |=> rd_data[6]);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> $past(rd_data[11] && rd_data[10]));

    // R10
    release_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_release && !$past(cmd_stop)) |-> (rd_data[7] && !rd_data[9] && !rd_data[8]));

    // R10
    release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_release |=> !bus_release);
endmodule

bind link_csr link_csr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_stop    (cmd_stop),
    .ev_miss     (ev_miss),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .bus_release (bus_release),
    .irq_n       (irq_n)
);

// File: tb/link_csr_tb.sv
module link_csr_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_data = '0;
    logic [11:0] rd_data;
    logic        cmd_start = 1'b0, cmd_stop = 1'b0;
    logic        rx_dis = 1'b0, tx_dis = 1'b0;
    logic [5:0]  ev = '0;   // 0 rint,1 tint,2 pint,3 tur,4 ror,5 miss
    logic        bm_addr = 1'b0, bm_ready = 1'b0;
    logic        bus_release, irq_n;
    int          vec = 0, bad = 0;
    bit          done = 1'b0;
    localparam logic [5:0] EV_IRQ = 6'b100111;

    always #10 clk = ~clk;

    link_csr u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .rx_dis(rx_dis), .tx_dis(tx_dis),
        .ev_miss(ev[5]), .ev_ror(ev[4]), .ev_tur(ev[3]), .ev_pint(ev[2]),
        .ev_tint(ev[1]), .ev_rint(ev[0]), .bm_addr(bm_addr), .bm_ready(bm_ready),
        .bus_release(bus_release), .irq_n(irq_n)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vec++; bad++;
        $display("FAIL watchdog: actual hang expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        chk("R1 reset rd", rd_data, 12'h000);
        chk("R1 reset irq_n", {11'b0, irq_n}, 12'h001);
        rst_n = 1'b1;
        tick();

        wr(12'hFFF);
        chk("R9 R11 R2 write while stopped", rd_data, 12'h000);

        tx_dis = 1'b1; cmd_start = 1'b1; tick(); cmd_start = 1'b0;
        chk("R3 start with tx disabled", rd_data, 12'h200);
        tx_dis = 1'b0; tick();
        chk("R3 tx on after disable falls", rd_data, 12'h300);
        tx_dis = 1'b1; tick();
        chk("R3 disable rise clears tx", rd_data, 12'h200);
        tx_dis = 1'b0; tick();
        chk("R3 tx back on", rd_data, 12'h300);

        wr(12'h800);
        chk("R9 ie set while running", rd_data, 12'hB00);

        for (int i = 0; i < 6; i++) begin
            logic [11:0] bitv, exp;
            logic        m;
            bitv = 12'(1) << (i + 1);
            m    = EV_IRQ[i];
            exp  = 12'hB00 | bitv | (m ? 12'h400 : 12'h000);
            ev[i] = 1'b1; tick(); ev = '0;
            chk("R5 R7 event sets flag", rd_data, exp);
            chk("R8 irq_n lags one cycle", {11'b0, irq_n}, 12'h001);
            tick();
            chk("R8 irq_n follows ie and summary", {11'b0, irq_n}, {11'b0, ~m});
            wr(12'h800);
            chk("R6 write 0 keeps flag", rd_data, exp);
            ev[i] = 1'b1; wr(12'h800 | bitv); ev = '0;
            chk("R5 set wins over clear", rd_data, exp);
            wr(12'h800 | bitv);
            chk("R6 write 1 clears flag", rd_data, 12'hB00);
            tick();
            chk("R8 irq_n released", {11'b0, irq_n}, 12'h001);
        end

        ev[0] = 1'b1; ev[4] = 1'b1; tick(); ev = '0;
        chk("R7 two flags", rd_data, 12'hF22);
        wr(12'h802);
        chk("R7 overrun alone no summary", rd_data, 12'hB20);
        wr(12'h820);

        ev[5] = 1'b1; tick(); ev = '0;
        chk("R7 miss pending", rd_data, 12'hF40);
        wr(12'h000);
        chk("R9 write 0 clears ie", rd_data, 12'h740);
        tick(); tick();
        chk("R8 pin high with ie off", {11'b0, irq_n}, 12'h001);
        wr(12'h840);
        chk("R9 R6 restore", rd_data, 12'hB00);

        bm_addr = 1'b1; tick(); bm_addr = 1'b0;
        repeat (255) tick();
        chk("R10 no timeout one edge early", rd_data, 12'hB00);
        tick();
        chk("R10 timeout sets merr and shuts down", rd_data, 12'hC80);
        chk("R10 bus release high", {11'b0, bus_release}, 12'h001);
        tick();
        chk("R10 bus release one cycle", {11'b0, bus_release}, 12'h000);
        chk("R8 pin low after merr", {11'b0, irq_n}, 12'h000);
        wr(12'h880);
        chk("R6 merr clear", rd_data, 12'h800);
        cmd_start = 1'b1; tick(); cmd_start = 1'b0;
        chk("R3 restart", rd_data, 12'hB00);

        bm_addr = 1'b1; tick(); bm_addr = 1'b0;
        repeat (255) tick();
        bm_ready = 1'b1; tick(); bm_ready = 1'b0;
        chk("R10 ready on last edge avoids timeout", rd_data, 12'hB00);
        chk("R10 no release", {11'b0, bus_release}, 12'h000);
        repeat (300) tick();
        chk("R10 monitor idle after ready", rd_data, 12'hB00);

        bm_addr = 1'b1; tick(); bm_addr = 1'b0;
        repeat (200) tick();
        bm_addr = 1'b1; tick(); bm_addr = 1'b0;
        repeat (255) tick();
        chk("R10 new address restarts count", rd_data, 12'hB00);
        tick();
        chk("R10 timeout after restart", rd_data, 12'hC80);

        cmd_stop = 1'b1; cmd_start = 1'b1; ev[1] = 1'b1; tick();
        cmd_stop = 1'b0; cmd_start = 1'b0; ev = '0;
        chk("R4 R12 stop wins", rd_data, 12'h000);
        wr(12'h800);
        chk("R9 ie locked while stopped", rd_data, 12'h000);
        tick();
        chk("R8 pin high when stopped", {11'b0, irq_n}, 12'h001);

        rx_dis = 1'b1; cmd_start = 1'b1; tick(); cmd_start = 1'b0;
        chk("R3 start with rx disabled", rd_data, 12'h100);
        rx_dis = 1'b0; tick();
        chk("R3 rx on after disable falls", rd_data, 12'h300);
        wr(12'hFFF);
        chk("R11 R2 write all ones running", rd_data, 12'hB00);
        cmd_stop = 1'b1; tick(); cmd_stop = 1'b0;
        chk("R4 stop clears", rd_data, 12'h000);

        finish_run();
    end
endmodule